// File: doc/BRIEF.md
# Fetch-Stage Branch Target and Direction Predictor

This block sits beside the fetch address register and answers one question each cycle: should fetch be redirected, and to where? It joins two structures. One is a small two-way set-associative target buffer that remembers the destination of branches seen before. The other is a large table of 2-bit saturating counters that says whether a branch is likely to be taken. A lookup is purely combinational on the fetch PC. It returns a hit flag, the remembered target, the counter's direction bit, and a redirect flag. On a miss, the returned target is the sequential fall-through address.

When a branch resolves further down the pipeline, the resolve port reports its PC, its outcome and its actual target. On that same clock edge the counter table and the target buffer are updated, each by its own rule. The counter always moves one step toward the outcome. The target buffer installs, refreshes or leaves an entry alone, depending on whether the branch hit and whether it was taken.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset every target buffer entry is invalid, so `pred_hit` is 0 for every PC. Every counter holds weakly-not-taken, so `pred_dir` is 0 for every PC.
- R2: The direction counter is selected by PC bits [12:2]. PCs that differ only above bit 12 share a counter. PCs that differ in bits [12:2] use separate counters.
- R3: Counter encoding is 00 strongly-not-taken, 01 weakly-not-taken, 10 weakly-taken and 11 strongly-taken, and `pred_dir` is bit 1 of the counter. A taken resolve adds one step and saturates at 11. A not-taken resolve removes one step and saturates at 00.
- R4: The target buffer set is PC bits [5:2] and the tag is PC bits [31:6]. A lookup hits only on a valid entry whose tag matches, so PC bits [1:0] do not affect the lookup.
- R5: A taken resolve that misses installs its tag and target into the least recently used way of its set. Way 0 is least recently used after reset. Each install or hit on a way makes that way most recently used.
- R6: A not-taken resolve that misses leaves the target buffer unchanged.
- R7: A taken resolve that hits overwrites the stored target. A not-taken resolve that hits keeps the stored target.
- R8: `pred_taken` is 1 exactly when `pred_hit` is 1 and `pred_dir` is 1. `pred_target` is the stored target on a hit and `fetch_pc + 4` (wrapping) on a miss.
- R9: Every resolve updates its counter, whether or not the branch hits the target buffer.
- R10: A lookup in the cycle of a resolve sees the state from before that resolve. The update becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | PC being fetched this cycle |
| pred_hit | output | 1 | Target buffer holds an entry for `fetch_pc` |
| pred_dir | output | 1 | Direction bit of the counter selected by `fetch_pc` |
| pred_taken | output | 1 | Redirect fetch to `pred_target` |
| pred_target | output | 32 | Predicted next PC |
| resolve_valid | input | 1 | A branch outcome is reported this cycle |
| resolve_pc | input | 32 | PC of the resolved branch |
| resolve_taken | input | 1 | Resolved outcome, 1 for taken |
| resolve_target | input | 32 | Actual target of the resolved branch |

## Verification
The bench builds the block with its default parameters: a 32-bit PC, 2048 counters and 16 target-buffer sets. With these values, PCs 0x1000, 0x3000 and 0x5000 land in the same set and on the same counter while carrying different tags. That single choice lets the bench show counter aliasing next to a tag miss, and lets it fill a set, refresh one way and evict the other. The top address 0xFFFFFFFC reaches the last set and the last counter, and it also exercises the wrap of the fall-through address.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // 2-bit direction counter states
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // One saturating step toward the observed outcome
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == CTR_ST)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  // Direction implied by a counter value
  function automatic logic ctr_taken(input logic [1:0] cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 2048,
  localparam int IDX_W  = $clog2(ENTRIES)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  logic [1:0] ctr_q [ENTRIES];
  logic [1:0] wr_cur;
  logic [1:0] wr_nxt;

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_cur = ctr_q[wr_idx];
  assign wr_nxt = ctr_step(wr_cur, wr_taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WNT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_nxt;
    end
  end

  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_cur == CTR_ST) |=> ctr_q[$past(wr_idx)] == CTR_ST); // R3
  AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_cur == CTR_SNT) |=> ctr_q[$past(wr_idx)] == CTR_SNT); // R3
  AST_CTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_cur != CTR_ST) |=> ctr_q[$past(wr_idx)] != $past(wr_cur)); // R9

endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer #(
  parameter int PC_W  = 32,
  parameter int SETS  = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = PC_W - 2 - SET_W,
  // a single LRU bit per set only orders two ways
  localparam int WAYS  = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_target,
  input  logic             up_en,
  input  logic [SET_W-1:0] up_set,
  input  logic [TAG_W-1:0] up_tag,
  input  logic             up_taken,
  input  logic [PC_W-1:0]  up_target
);

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SETS-1:0]           lru_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic [PC_W-1:0]           tgt_q [SETS][WAYS];

  logic [WAYS-1:0] lk_match;
  logic [WAYS-1:0] up_match;
  logic            up_hit;
  logic            hit_way;
  logic            victim;

  // named events for the checks below
  logic install_evt;
  logic refresh_evt;
  logic touch_evt;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lk_match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign up_match[w] = valid_q[up_set][w] && (tag_q[up_set][w] == up_tag);
  end

  assign lk_hit    = |lk_match;
  assign lk_target = lk_match[1] ? tgt_q[lk_set][1] : tgt_q[lk_set][0];

  assign up_hit  = |up_match;
  assign hit_way = up_match[1];
  assign victim  = lru_q[up_set];

  assign install_evt = up_en && !up_hit && up_taken;
  assign refresh_evt = up_en && up_hit && up_taken;
  assign touch_evt   = up_en && up_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lru_q   <= '0;
    end else if (install_evt) begin
      valid_q[up_set][victim] <= 1'b1;
      lru_q[up_set]           <= ~victim;
    end else if (touch_evt) begin
      lru_q[up_set]           <= ~hit_way;
    end
  end

  always_ff @(posedge clk) begin
    if (install_evt) begin
      tag_q[up_set][victim] <= up_tag;
      tgt_q[up_set][victim] <= up_target;
    end else if (refresh_evt) begin
      tgt_q[up_set][hit_way] <= up_target;
    end
  end

  AST_LOOKUP_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R4
  AST_INSTALL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    install_evt |=> valid_q[$past(up_set)][$past(victim)]); // R5
  AST_INSTALL_MAKES_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    install_evt |=> lru_q[$past(up_set)] != $past(victim)); // R5
  AST_NT_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !up_taken && !up_hit) |=> $stable(valid_q)); // R6
  AST_REFRESH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_evt |=> tgt_q[$past(up_set)][$past(hit_way)] == $past(up_target)); // R7

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int CTR_ENTS = 2048,
  parameter int BTB_SETS = 16,
  localparam int CIDX_W  = $clog2(CTR_ENTS),
  localparam int SET_W   = $clog2(BTB_SETS),
  localparam int TAG_W   = PC_W - 2 - SET_W
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_dir,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  input  logic            resolve_valid,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken,
  input  logic [PC_W-1:0] resolve_target
);

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  function automatic logic [CIDX_W-1:0] ctr_index(input logic [PC_W-1:0] pc);
    return pc[CIDX_W+1:2];
  endfunction

  function automatic logic [SET_W-1:0] set_index(input logic [PC_W-1:0] pc);
    return pc[SET_W+1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_bits(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:SET_W+2];
  endfunction

  logic [1:0]      fetch_ctr;
  logic            btb_hit;
  logic [PC_W-1:0] btb_target;
  logic            unused_resolve_lsb;

  assign unused_resolve_lsb = ^resolve_pc[1:0];

  bp_counter_table #(
    .ENTRIES (CTR_ENTS)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (ctr_index(fetch_pc)),
    .rd_ctr   (fetch_ctr),
    .wr_en    (resolve_valid),
    .wr_idx   (ctr_index(resolve_pc)),
    .wr_taken (resolve_taken)
  );

  bp_target_buffer #(
    .PC_W (PC_W),
    .SETS (BTB_SETS)
  ) u_btb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (set_index(fetch_pc)),
    .lk_tag    (tag_bits(fetch_pc)),
    .lk_hit    (btb_hit),
    .lk_target (btb_target),
    .up_en     (resolve_valid),
    .up_set    (set_index(resolve_pc)),
    .up_tag    (tag_bits(resolve_pc)),
    .up_taken  (resolve_taken),
    .up_target (resolve_target)
  );

  assign pred_hit    = btb_hit;
  assign pred_dir    = ctr_taken(fetch_ctr);
  assign pred_taken  = btb_hit && pred_dir;
  assign pred_target = btb_hit ? btb_target : seq_next(fetch_pc);

  AST_RESOLVE_SEEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_valid && resolve_taken && $stable(fetch_pc) && fetch_pc == resolve_pc)
      |=> pred_hit); // R10

endmodule

// File: tb/bp_fetch_predictor_test.sv
module bp_fetch_predictor_test;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred_hit;
  logic        pred_dir;
  logic        pred_taken;
  logic [31:0] pred_target;
  logic        resolve_valid;
  logic [31:0] resolve_pc;
  logic        resolve_taken;
  logic [31:0] resolve_target;

  bp_fetch_predictor uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_pc       (fetch_pc),
    .pred_hit       (pred_hit),
    .pred_dir       (pred_dir),
    .pred_taken     (pred_taken),
    .pred_target    (pred_target),
    .resolve_valid  (resolve_valid),
    .resolve_pc     (resolve_pc),
    .resolve_taken  (resolve_taken),
    .resolve_target (resolve_target)
  );

  typedef struct {
    logic        hit;
    logic [31:0] tgt;
    logic        tk;
    logic        dir;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // driver: apply a fetch PC and queue what the outputs must show
  task automatic look(input logic [31:0] pc, input logic hit, input logic [31:0] tgt,
                      input logic tk, input logic dir, input string tag);
    exp_t e;
    @(negedge clk);
    fetch_pc = pc;
    e.hit = hit; e.tgt = tgt; e.tk = tk; e.dir = dir; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    resolve_valid  = 1'b1;
    resolve_pc     = pc;
    resolve_taken  = tk;
    resolve_target = tgt;
    @(posedge clk);
    #1 resolve_valid = 1'b0;
  endtask

  // resolve and lookup in one cycle
  task automatic res_look(input logic [31:0] rpc, input logic tk, input logic [31:0] rtgt,
                          input logic [31:0] lpc, input logic hit, input logic [31:0] tgt,
                          input logic etk, input logic dir, input string tag);
    exp_t e;
    @(negedge clk);
    resolve_valid  = 1'b1;
    resolve_pc     = rpc;
    resolve_taken  = tk;
    resolve_target = rtgt;
    fetch_pc       = lpc;
    e.hit = hit; e.tgt = tgt; e.tk = etk; e.dir = dir; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
    #1 resolve_valid = 1'b0;
  endtask

  // monitor: compare a quarter period after each falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        total++;
        if (pred_hit !== e.hit || pred_target !== e.tgt ||
            pred_taken !== e.tk || pred_dir !== e.dir) begin
          bad++;
          $display("FAIL %s: got hit=%0b tgt=%h taken=%0b dir=%0b exp hit=%0b tgt=%h taken=%0b dir=%0b",
                   e.tag, pred_hit, pred_target, pred_taken, pred_dir,
                   e.hit, e.tgt, e.tk, e.dir);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_pc = '0;
    resolve_valid = 1'b0;
    resolve_pc = '0;
    resolve_taken = 1'b0;
    resolve_target = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, R8 fall-through with wrap
    look(32'h1000, 0, 32'h1004, 0, 0, "R1 empty");
    look(32'hFFFF_FFFC, 0, 32'h0000_0000, 0, 0, "R1 R8 wrap");

    // R6 not-taken miss installs nothing (counter 01->00)
    resolve(32'h1000, 0, 32'h2000);
    look(32'h1000, 0, 32'h1004, 0, 0, "R6 no install");

    // R5 taken miss installs; counter 00->01, so no redirect (R8)
    resolve(32'h1000, 1, 32'h2000);
    look(32'h1000, 1, 32'h2000, 0, 0, "R5 R8 weak");
    resolve(32'h1000, 1, 32'h2000);  // 10
    look(32'h1000, 1, 32'h2000, 1, 1, "R3 R8 redirect");

    // R3 saturation high
    resolve(32'h1000, 1, 32'h2000);  // 11
    resolve(32'h1000, 1, 32'h2000);  // 11
    resolve(32'h1000, 0, 32'h2000);  // 10
    look(32'h1000, 1, 32'h2000, 1, 1, "R3 sat high");

    // R7 not-taken hit keeps target
    resolve(32'h1000, 0, 32'h9999_0000);  // 01
    look(32'h1000, 1, 32'h2000, 0, 0, "R7 nt keeps");

    // R3 saturation low
    resolve(32'h1000, 0, 32'h2000);  // 00
    resolve(32'h1000, 0, 32'h2000);  // 00
    resolve(32'h1000, 1, 32'h2000);  // 01
    look(32'h1000, 1, 32'h2000, 0, 0, "R3 sat low");
    resolve(32'h1000, 1, 32'h2000);  // 10
    look(32'h1000, 1, 32'h2000, 1, 1, "R3 step up");

    // R7 taken hit refreshes target (counter 11)
    resolve(32'h1000, 1, 32'h3000);
    look(32'h1000, 1, 32'h3000, 1, 1, "R7 refresh");
    look(32'h1002, 1, 32'h3000, 1, 1, "R4 low bits ignored");

    // R2 aliasing, R4 tag miss
    look(32'h3000, 0, 32'h3004, 0, 1, "R2 R4 alias");
    look(32'h1004, 0, 32'h1008, 0, 0, "R2 neighbour");

    // R5 second way, then LRU eviction
    resolve(32'h3000, 1, 32'h4000);
    look(32'h1000, 1, 32'h3000, 1, 1, "R5 first way kept");
    look(32'h3000, 1, 32'h4000, 1, 1, "R5 second way");
    resolve(32'h1000, 1, 32'h3000);   // way0 becomes MRU
    resolve(32'h5000, 1, 32'h6000);   // evicts way1
    look(32'h3000, 0, 32'h3004, 0, 1, "R5 LRU evicted");
    look(32'h1000, 1, 32'h3000, 1, 1, "R5 MRU kept");
    look(32'h5000, 1, 32'h6000, 1, 1, "R5 installed");

    // R9 counter moves regardless of target buffer outcome
    resolve(32'h0000_0010, 0, 32'h8000);   // 00, no install
    look(32'h0000_0010, 0, 32'h0000_0014, 0, 0, "R9 R6 miss update");
    resolve(32'h0000_0010, 1, 32'h8000);   // 01, install
    look(32'h0000_0010, 1, 32'h8000, 0, 0, "R9 install");
    resolve(32'h0000_0010, 1, 32'h8000);   // 10
    look(32'h0000_0010, 1, 32'h8000, 1, 1, "R9 hit update");

    // R10 same-cycle lookup sees old state
    res_look(32'h0000_0020, 1, 32'h7000,
             32'h0000_0020, 0, 32'h0000_0024, 0, 0, "R10 same cycle");
    look(32'h0000_0020, 1, 32'h7000, 1, 1, "R10 R1 next cycle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule